// File: doc/BRIEF.md
# Translation Fault Status and Error Interrupt

This block is the fault-reporting corner of an I/O address translation unit. When the translator reports that a DMA address could not be mapped, the block records the failing address and raises one level-sensitive error interrupt line toward the system's interrupt controller. Software services the interrupt through a small word-addressed register window. Any read or write of either the fault-address word or the fault-status word drops the line.

The same window holds a control word, an arbiter-enable word and a page-flush word. Each has a fixed reset value or a write mask. The remaining word slots are plain storage. Reads return data one cycle after the read strobe. The interrupt is driven by a two-state machine. IRQ_QUIET moves to IRQ_RAISED through the transition "fault". IRQ_RAISED moves back to IRQ_QUIET through the transition "service", which is a read or write of the fault-address or fault-status word in a cycle with no fault. A fault in IRQ_RAISED takes the transition "refault" and the machine stays in IRQ_RAISED.

Word indices are parameters. The defaults are: control 0, arbiter-enable 1, page-flush 2, fault status 3, fault address 4, and plain storage at 5 to 7.

Top module: `iofault_unit`

## Requirements
- R1: After reset, the outputs and stored words take fixed values. `err_irq` is 0 and `reg_rdata` is 0. The control word holds CTRL_RESET and the arbiter-enable word holds ARB_RESET. The fault-status word holds STAT_RSVD. The page-flush, fault-address and plain words hold 0.
- R2: A cycle with `flt_valid` high stores `flt_addr` into the fault-address word and sets `err_irq` high at that clock edge.
- R3: A fault with `flt_is_read`=1 ORs bit RD_BIT (default 23) into the fault-status word. A fault with `flt_is_read`=0 leaves the fault-status word unchanged.
- R4: A read with `reg_rd` high returns the addressed word on `reg_rdata` after the same clock edge. The read returns the word's value before that edge, and `reg_rdata` holds until the next read. A read of the fault-address or fault-status word in a cycle without a fault clears `err_irq` at that same edge.
- R5: A write to the fault-address word in a cycle without a fault stores all 32 bits of `reg_wdata` and clears `err_irq`.
- R6: A write to the fault-status word in a cycle without a fault stores (`reg_wdata` AND STAT_WMASK) OR STAT_RSVD and clears `err_irq`. The STAT_RSVD bits stay set in the fault-status word at all times.
- R7: A write to the page-flush word stores `reg_wdata` AND FLUSH_WMASK.
- R8: Reads and writes of the control, arbiter-enable, page-flush and plain words leave `err_irq` unchanged. Writes to the control, arbiter-enable and plain words store `reg_wdata` unchanged.
- R9: When a fault and an access to the fault-address or fault-status word fall in the same cycle, the fault wins. The fault's address and status are stored, any such write is discarded, and `err_irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Word index into the register window |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid from the edge that takes the read strobe |
| flt_valid | input | 1 | Translation fault report, one cycle per fault |
| flt_addr | input | DW | DMA address that failed to translate |
| flt_is_read | input | 1 | 1 when the failing access was a read |
| err_irq | output | 1 | Level-sensitive error interrupt |

## Verification
The assertions assume that the strobes, the fault flag and the word index are known, never X, in every cycle after reset. They also assume that a fault is reported as a pulse sampled once per edge. They make no assumption about how reads, writes and faults overlap. For that reason the bench drives every input from a single task that sets all of them at the falling edge and clears them one step after the rising edge. The bench deliberately places faults in the same cycle as reads and writes of both interrupt-clearing words, so that the fault-wins case is exercised under the same input assumptions.

// File: rtl/iofault_pkg.sv
package iofault_pkg;

    // Function of one word slot in the register window.
    typedef enum logic [2:0] {
        ROLE_CTRL,
        ROLE_ARB,
        ROLE_FLUSH,
        ROLE_STAT,
        ROLE_ADDR,
        ROLE_PLAIN
    } reg_role_e;

    // Interrupt line states.
    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

    // Map a word index onto its role from the configured slot numbers.
    function automatic reg_role_e role_of(input int idx, input int ix_ctrl,
                                          input int ix_arb, input int ix_flush,
                                          input int ix_stat, input int ix_addr);
        if (idx == ix_ctrl)       return ROLE_CTRL;
        else if (idx == ix_arb)   return ROLE_ARB;
        else if (idx == ix_flush) return ROLE_FLUSH;
        else if (idx == ix_stat)  return ROLE_STAT;
        else if (idx == ix_addr)  return ROLE_ADDR;
        else                      return ROLE_PLAIN;
    endfunction

endpackage

// File: rtl/iofault_decode.sv
module iofault_decode
    import iofault_pkg::*;
#(
    parameter int AW       = 3,
    parameter int IX_CTRL  = 0,
    parameter int IX_ARB   = 1,
    parameter int IX_FLUSH = 2,
    parameter int IX_STAT  = 3,
    parameter int IX_ADDR  = 4
) (
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    output reg_role_e     role,
    output logic          service_hit
);

    always_comb begin
        role = role_of(int'(reg_addr), IX_CTRL, IX_ARB, IX_FLUSH, IX_STAT, IX_ADDR);
        service_hit = (reg_rd || reg_wr) && ((role == ROLE_STAT) || (role == ROLE_ADDR));
    end

endmodule

// File: rtl/iofault_irq_fsm.sv
module iofault_irq_fsm
    import iofault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic service,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    // Next state: fault, refault and service transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (fault) state_d = IRQ_RAISED;
            end
            IRQ_RAISED: begin
                if (!fault && service) state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/iofault_regfile.sv
module iofault_regfile
    import iofault_pkg::*;
#(
    parameter int          AW          = 3,
    parameter int          DW          = 32,
    parameter int          IX_CTRL     = 0,
    parameter int          IX_ARB      = 1,
    parameter int          IX_FLUSH    = 2,
    parameter int          IX_STAT     = 3,
    parameter int          IX_ADDR     = 4,
    parameter int          RD_BIT      = 23,
    parameter logic [DW-1:0] STAT_WMASK  = 32'hFFFF_FFFF,
    parameter logic [DW-1:0] STAT_RSVD   = 32'h0000_0000,
    parameter logic [DW-1:0] FLUSH_WMASK = 32'hFFFF_F000,
    parameter logic [DW-1:0] CTRL_RESET  = 32'h0400_0000,
    parameter logic [DW-1:0] ARB_RESET   = 32'h0000_0008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          flt_valid,
    input  logic [DW-1:0] flt_addr,
    input  logic          flt_is_read,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] addr_q
);

    localparam int NWORDS = 1 << AW;
    localparam logic [DW-1:0] RD_FLAG = DW'(1) << RD_BIT;

    logic [DW-1:0] word_q [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        localparam reg_role_e ROLE = role_of(i, IX_CTRL, IX_ARB, IX_FLUSH, IX_STAT, IX_ADDR);
        logic wr_hit;
        assign wr_hit = reg_wr && (reg_addr == AW'(i));

        if (ROLE == ROLE_CTRL || ROLE == ROLE_ARB) begin : g_fixed
            localparam logic [DW-1:0] INIT = (ROLE == ROLE_CTRL) ? CTRL_RESET : ARB_RESET;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      word_q[i] <= INIT;
                else if (wr_hit) word_q[i] <= reg_wdata;
            end
        end else if (ROLE == ROLE_FLUSH) begin : g_flush
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      word_q[i] <= '0;
                else if (wr_hit) word_q[i] <= reg_wdata & FLUSH_WMASK;
            end
        end else if (ROLE == ROLE_STAT) begin : g_stat
            // A fault owns this word in its cycle; a write then is dropped.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q[i] <= STAT_RSVD;
                end else if (flt_valid) begin
                    if (flt_is_read) word_q[i] <= word_q[i] | RD_FLAG;
                end else if (wr_hit) begin
                    word_q[i] <= (reg_wdata & STAT_WMASK) | STAT_RSVD;
                end
            end
        end else if (ROLE == ROLE_ADDR) begin : g_addr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         word_q[i] <= '0;
                else if (flt_valid) word_q[i] <= flt_addr;
                else if (wr_hit)    word_q[i] <= reg_wdata;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      word_q[i] <= '0;
                else if (wr_hit) word_q[i] <= reg_wdata;
            end
        end
    end

    // Registered read port: data appears on the edge that takes the strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= word_q[reg_addr];
    end

    always_comb begin
        stat_q = word_q[IX_STAT];
        addr_q = word_q[IX_ADDR];
    end

endmodule

// File: rtl/iofault_unit.sv
module iofault_unit
    import iofault_pkg::*;
#(
    parameter int          AW          = 3,
    parameter int          DW          = 32,
    parameter int          IX_CTRL     = 0,
    parameter int          IX_ARB      = 1,
    parameter int          IX_FLUSH    = 2,
    parameter int          IX_STAT     = 3,
    parameter int          IX_ADDR     = 4,
    parameter int          RD_BIT      = 23,
    parameter logic [DW-1:0] STAT_WMASK  = 32'hFFFF_FFFF,
    parameter logic [DW-1:0] STAT_RSVD   = 32'h0000_0000,
    parameter logic [DW-1:0] FLUSH_WMASK = 32'hFFFF_F000,
    parameter logic [DW-1:0] CTRL_RESET  = 32'h0400_0000,
    parameter logic [DW-1:0] ARB_RESET   = 32'h0000_0008
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          flt_valid,
    input  logic [DW-1:0] flt_addr,
    input  logic          flt_is_read,
    output logic          err_irq
);

    reg_role_e     acc_role;
    logic          service_hit;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] addr_q;

    iofault_decode #(
        .AW(AW), .IX_CTRL(IX_CTRL), .IX_ARB(IX_ARB), .IX_FLUSH(IX_FLUSH),
        .IX_STAT(IX_STAT), .IX_ADDR(IX_ADDR)
    ) u_decode (
        .reg_addr    (reg_addr),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .role        (acc_role),
        .service_hit (service_hit)
    );

    iofault_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (flt_valid),
        .service (service_hit),
        .irq     (err_irq)
    );

    iofault_regfile #(
        .AW(AW), .DW(DW), .IX_CTRL(IX_CTRL), .IX_ARB(IX_ARB), .IX_FLUSH(IX_FLUSH),
        .IX_STAT(IX_STAT), .IX_ADDR(IX_ADDR), .RD_BIT(RD_BIT),
        .STAT_WMASK(STAT_WMASK), .STAT_RSVD(STAT_RSVD), .FLUSH_WMASK(FLUSH_WMASK),
        .CTRL_RESET(CTRL_RESET), .ARB_RESET(ARB_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .flt_valid   (flt_valid),
        .flt_addr    (flt_addr),
        .flt_is_read (flt_is_read),
        .reg_rdata   (reg_rdata),
        .stat_q      (stat_q),
        .addr_q      (addr_q)
    );

endmodule

// File: rtl/iofault_unit_chk.sv
module iofault_unit_chk #(
    parameter int          AW         = 3,
    parameter int          DW         = 32,
    parameter int          IX_STAT    = 3,
    parameter int          IX_ADDR    = 4,
    parameter int          RD_BIT     = 23,
    parameter logic [DW-1:0] STAT_WMASK = 32'hFFFF_FFFF,
    parameter logic [DW-1:0] STAT_RSVD  = 32'h0000_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic          flt_valid,
    input logic [DW-1:0] flt_addr,
    input logic          flt_is_read,
    input logic          err_irq,
    input logic [DW-1:0] stat_q,
    input logic [DW-1:0] addr_q
);

    logic hit_stat, hit_addr, svc;
    assign hit_stat = (reg_addr == AW'(IX_STAT));
    assign hit_addr = (reg_addr == AW'(IX_ADDR));
    assign svc      = (reg_rd || reg_wr) && (hit_stat || hit_addr);

    // R2 and R9: a fault captures its address and leaves the line high.
    a_r2_fault_raises: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> err_irq);
    a_r2_addr_captured: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> (addr_q == $past(flt_addr)));

    // R3: read fault sets the flag, write fault leaves status alone.
    a_r3_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_is_read) |=> stat_q[RD_BIT]);
    a_r3_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_is_read) |=> (stat_q == $past(stat_q)));

    // R4, R5, R6: servicing access without a fault drops the line.
    a_r4_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !flt_valid) |=> !err_irq);

    // R5: full-width store into the fault-address word.
    a_r5_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_addr && !flt_valid) |=> (addr_q == $past(reg_wdata)));

    // R6: masked store, reserved bits always present.
    a_r6_stat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_stat && !flt_valid) |=>
            (stat_q == (($past(reg_wdata) & STAT_WMASK) | STAT_RSVD)));
    a_r6_rsvd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & STAT_RSVD) == STAT_RSVD));

    // R8: no fault and no servicing access leaves the line where it was.
    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_valid && !svc) |=> (err_irq == $past(err_irq)));

endmodule

bind iofault_unit iofault_unit_chk #(
    .AW(AW), .DW(DW), .IX_STAT(IX_STAT), .IX_ADDR(IX_ADDR), .RD_BIT(RD_BIT),
    .STAT_WMASK(STAT_WMASK), .STAT_RSVD(STAT_RSVD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .flt_valid   (flt_valid),
    .flt_addr    (flt_addr),
    .flt_is_read (flt_is_read),
    .err_irq     (err_irq),
    .stat_q      (stat_q),
    .addr_q      (addr_q)
);

// File: tb/iofault_unit_test.sv
`timescale 1ns/1ps
module iofault_unit_test;

    localparam int          AW    = 3;
    localparam int          DW    = 32;
    localparam int          NW    = 1 << AW;
    localparam int          RDB   = 23;
    localparam logic [31:0] SMASK = 32'h00FF_FF0F;
    localparam logic [31:0] SRSV  = 32'h0000_0030;
    localparam logic [31:0] FMASK = 32'hFFFF_F000;
    localparam logic [31:0] CRST  = 32'h0400_0000;
    localparam logic [31:0] ARST  = 32'h0000_0008;
    // Word indices: ctrl 0, arb 1, flush 2, status 3, address 4, plain 5..7.

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          flt_valid = 1'b0;
    logic [DW-1:0] flt_addr = '0;
    logic          flt_is_read = 1'b0;
    logic          err_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] mdl [NW];
    logic        mdl_irq;

    iofault_unit #(
        .AW(AW), .DW(DW), .RD_BIT(RDB), .STAT_WMASK(SMASK), .STAT_RSVD(SRSV),
        .FLUSH_WMASK(FMASK), .CTRL_RESET(CRST), .ARB_RESET(ARST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .flt_is_read(flt_is_read),
        .err_irq(err_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; the model is updated from the requirements.
    task automatic step(input string req, input bit rd, input bit wr, input int idx,
                        input logic [31:0] wd, input bit flt, input logic [31:0] fa,
                        input bit frd);
        logic [31:0] exp_rd;
        bit svc;
        exp_rd = mdl[idx];
        svc = (rd || wr) && (idx == 3 || idx == 4);
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_addr = AW'(idx); reg_wdata = wd;
        flt_valid = flt; flt_addr = fa; flt_is_read = frd;
        @(posedge clk);
        #1;
        reg_rd = 1'b0; reg_wr = 1'b0; flt_valid = 1'b0;
        if (wr && !(flt && (idx == 3 || idx == 4))) begin
            case (idx)
                2:       mdl[idx] = wd & FMASK;
                3:       mdl[idx] = (wd & SMASK) | SRSV;
                default: mdl[idx] = wd;
            endcase
        end
        if (flt) begin
            mdl[4] = fa;
            if (frd) mdl[3] = mdl[3] | (32'h1 << RDB);
            mdl_irq = 1'b1;
        end else if (svc) begin
            mdl_irq = 1'b0;
        end
        if (rd) check({req, " rdata"}, reg_rdata, exp_rd);
        check({req, " irq"}, {31'd0, err_irq}, {31'd0, mdl_irq});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [5];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h1234_5678; pats[4] = 32'h5A5A_A5A5;
        for (int i = 0; i < NW; i++) mdl[i] = 32'h0;
        mdl[0] = CRST; mdl[1] = ARST; mdl[3] = SRSV; mdl_irq = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        // R1: reset values at the ports
        check("R1 irq at reset", {31'd0, err_irq}, 32'd0);
        check("R1 rdata at reset", reg_rdata, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: every word reads back its reset value
        for (int i = 0; i < NW; i++) step("R1 reset word", 1, 0, i, 0, 0, 0, 0);

        // R7 R8 R5 R6 R4: write/read sweep over every word and pattern
        for (int p = 0; p < 5; p++)
            for (int i = 0; i < NW; i++) begin
                step("R7 R8 sweep write", 0, 1, i, pats[p] ^ (32'h0101_0101 * i), 0, 0, 0);
                step("R4 sweep read", 1, 0, i, 0, 0, 0, 0);
            end
        step("R6 rsvd bits", 0, 1, 3, 32'h0, 0, 0, 0);
        step("R6 rsvd readback", 1, 0, 3, 0, 0, 0, 0);

        // R2 R3: read fault sets flag and raises the line
        step("R2 read fault", 0, 0, 0, 0, 1, 32'hDEAD_B000, 1);
        step("R8 ctrl read keeps irq", 1, 0, 0, 0, 0, 0, 0);
        step("R8 flush write keeps irq", 0, 1, 2, 32'hFFFF_FFFF, 0, 0, 0);
        step("R8 plain write keeps irq", 0, 1, 6, 32'h1111_2222, 0, 0, 0);
        step("R3 status after read fault", 1, 0, 3, 0, 0, 0, 0);
        step("R4 addr read after clear", 1, 0, 4, 0, 0, 0, 0);

        // R3: write fault leaves status alone; R4 address read clears
        step("R6 clear status", 0, 1, 3, 32'h0, 0, 0, 0);
        step("R3 write fault", 0, 0, 0, 0, 1, 32'h0BAD_0004, 0);
        step("R4 addr read clears", 1, 0, 4, 0, 0, 0, 0);
        step("R3 status unchanged", 1, 0, 3, 0, 0, 0, 0);

        // R5: address write clears
        step("R2 fault", 0, 0, 0, 0, 1, 32'h7777_0000, 1);
        step("R5 addr write clears", 0, 1, 4, 32'hCAFE_F00D, 0, 0, 0);
        step("R5 addr readback", 1, 0, 4, 0, 0, 0, 0);

        // R6: status write clears
        step("R2 fault", 0, 0, 0, 0, 1, 32'h6666_0000, 0);
        step("R6 status write clears", 0, 1, 3, 32'hFFFF_FFFF, 0, 0, 0);
        step("R6 status readback", 1, 0, 3, 0, 0, 0, 0);

        // R9: fault beats concurrent servicing accesses
        step("R9 fault with addr read", 1, 0, 4, 0, 1, 32'h1357_9BDF, 0);
        step("R9 fault with status write", 0, 1, 3, 32'h0, 1, 32'h2468_ACE0, 1);
        step("R9 fault with addr write", 0, 1, 4, 32'hFFFF_0000, 1, 32'h0F0F_0F0F, 0);
        step("R9 status kept", 1, 0, 3, 0, 0, 0, 0);
        step("R9 addr kept", 1, 0, 4, 0, 0, 0, 0);

        // R2 R3: fault sweep with alternating direction
        for (int k = 0; k < 16; k++) begin
            step("R6 status reset", 0, 1, 3, 32'h0, 0, 0, 0);
            step("R2 R3 fault sweep", 0, 0, 5, 0, 1, 32'h1000_0000 * k + k, k[0]);
            step("R2 sweep addr read", 1, 0, 4, 0, 0, 0, 0);
            step("R3 sweep status read", 1, 0, 3, 0, 0, 0, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule